// File: doc/BRIEF.md
# Pixel Colour Palette with Display-Type Formatting

This block sits in an LCD pixel pipeline between pixel fetch and the panel data pins. It holds a 256-entry colour table of 16-bit words. Each word packs a 5-bit red field, a 6-bit green field and a 5-bit blue field. A pixel index of 1, 2, 4 or 8 bits comes in each cycle. One cycle later the selected entry comes out, already arranged for the chosen panel type.

Three panel arrangements are supported:
- **Grey-scale STN**: only the top four bits of red are kept, giving 16 levels.
- **Colour STN**: the top four bits of each of the three fields are kept, giving 4096 colours.
- **TFT**: the full 5-6-5 colour is spread over a 24-bit bus, with fixed bit positions held at zero.

A host loads and inspects the table through a 32-bit register-style port. Each entry sits in the low half of a word-aligned location. Any write that does not carry all four byte strobes is refused and reported.

Unpalettised modes, dithering, pixel fetch and timing generation are outside this block.

Top module: `lcd_palette_lut`

## Requirements
- R1: A host write (`host_req`=1, `host_we`=1, `host_be`=4'hF) stores `host_wdata[15:0]` into the entry selected by `host_addr[9:2]`. Bits 31:16 of the write data and `host_addr[1:0]` have no effect. Entry layout is red=[15:11], green=[10:5], blue=[4:0].
- R2: A host read (`host_req`=1, `host_we`=0) is answered in the following cycle: `host_rvalid`=1, `host_rdata[15:0]` holds the entry and `host_rdata[31:16]` is zero. When `host_rvalid`=0, `host_rdata` is zero.
- R3: A host write whose `host_be` is not 4'hF leaves the table unchanged. It raises `host_err` for exactly the following cycle. No other access raises `host_err`.
- R4: A lookup presented with `pix_valid`=1 appears on `out_data` one cycle later with `out_valid`=1. While `out_valid`=0, `out_data` is zero.
- R5: `pix_bpp` selects the index width: 0→1 bit, 1→2 bits, 2→4 bits, 3→8 bits. Index bits above the selected width are ignored (the index is zero-extended).
- R6: With `disp_mode`=0 (grey-scale STN), `out_data[3:0]` = red[4:1] and bits 23:4 are zero.
- R7: With `disp_mode`=1 (colour STN), `out_data[11:8]` = red[4:1], `[7:4]` = green[5:2] and `[3:0]` = blue[4:1]. Bits 23:12 are zero.
- R8: With `disp_mode`=2 (TFT), `out_data[23:19]` = blue, `[15:10]` = green and `[7:3]` = red. Bits 18:16, 9:8 and 2:0 are zero.
- R9: With `disp_mode`=3 (reserved), a valid lookup outputs all zeros.
- R10: When a host write and a lookup target the same entry in the same cycle, the lookup returns the value held before the write. Later lookups return the new value.
- R11: `disp_mode` and `pix_bpp` are sampled together with the index, in the cycle `pix_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, deasserted in step with `clk` |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 10 | Byte address; bits 9:2 pick the entry |
| host_be | input | 4 | Byte strobes; only 4'hF writes are accepted |
| host_wdata | input | 32 | Write data; low 16 bits used |
| host_rvalid | output | 1 | Read data valid (one cycle after the read request) |
| host_rdata | output | 32 | Read data, entry in bits 15:0 |
| host_err | output | 1 | One-cycle pulse after a refused partial write |
| pix_valid | input | 1 | Lookup request |
| pix_idx | input | 8 | Pixel index |
| pix_bpp | input | 2 | Index width code |
| disp_mode | input | 2 | Panel arrangement code |
| out_valid | output | 1 | Formatted pixel valid |
| out_data | output | 24 | Formatted pixel data |

## Verification
The bench targets these corner cases:
- **Same-cycle collision.** A write and a lookup hit the same entry in one cycle. A design that forwarded the new value would show the fresh colour one cycle early.
- **Partial-strobe writes.** These are followed by a readback. A block that honoured them would corrupt the entry, or would fail to pulse the error flag.
- **Indices with junk in the upper bits.** These are sent under every width code. Missing zero-extension would fetch the wrong entry.
- **Entries with every field bit exercised.** These are sent under all four panel codes. A shifted field or a stray bit in the zeroed TFT positions shows up as a data mismatch, as does leaking low-order bits in the STN modes.

// File: rtl/lcd_pal_pkg.sv
package lcd_pal_pkg;

  localparam int RED_W    = 5;
  localparam int GRN_W    = 6;
  localparam int BLU_W    = 5;
  localparam int ENTRY_W  = RED_W + GRN_W + BLU_W;
  localparam int STN_W    = 4;
  localparam int PIX_OUT_W = 24;

  typedef enum logic [1:0] {
    DISP_STN_GREY  = 2'd0,
    DISP_STN_COLOR = 2'd1,
    DISP_TFT       = 2'd2,
    DISP_RSVD      = 2'd3
  } disp_mode_e;

  typedef struct packed {
    logic [RED_W-1:0] red;
    logic [GRN_W-1:0] grn;
    logic [BLU_W-1:0] blu;
  } pal_entry_t;

endpackage

// File: rtl/pal_index_ext.sv
module pal_index_ext #(
  parameter int IDX_W = 8
) (
  input  logic [1:0]       bpp_code,
  input  logic [IDX_W-1:0] idx_in,
  output logic [IDX_W-1:0] idx_out
);

  localparam int N_CODES = 4;

  function automatic logic [IDX_W-1:0] low_mask(input int width);
    logic [IDX_W-1:0] m;
    m = '0;
    for (int b = 0; b < IDX_W; b++) begin
      if (b < width) m[b] = 1'b1;
    end
    return m;
  endfunction

  logic [IDX_W-1:0] masks [N_CODES];

  for (genvar g = 0; g < N_CODES; g++) begin : g_mask
    localparam int WIDTH = ((1 << g) < IDX_W) ? (1 << g) : IDX_W;
    assign masks[g] = low_mask(WIDTH);
  end

  always_comb begin
    idx_out = idx_in & masks[bpp_code];
  end

endmodule

// File: rtl/pal_ram.sv
module pal_ram #(
  parameter int IDX_W   = 8,
  parameter int ENTRY_W = 16
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic               pa_en,
  input  logic [IDX_W-1:0]   pa_idx,
  output logic [ENTRY_W-1:0] pa_data,
  input  logic               pb_en,
  input  logic [IDX_W-1:0]   pb_idx,
  output logic [ENTRY_W-1:0] pb_data
);

  localparam int DEPTH = 1 << IDX_W;

  logic [ENTRY_W-1:0] mem [DEPTH];

  // Storage array: no reset, written under its own enable.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  // Read ports sample the array before the same-edge write lands.
  always_ff @(posedge clk) begin
    if (pa_en) pa_data <= mem[pa_idx];
  end

  always_ff @(posedge clk) begin
    if (pb_en) pb_data <= mem[pb_idx];
  end

endmodule

// File: rtl/pal_host_port.sv
module pal_host_port #(
  parameter int IDX_W   = 8,
  parameter int ENTRY_W = 16,
  parameter int BUS_W   = 32,
  localparam int ADDR_W = IDX_W + 2,
  localparam int BE_W   = BUS_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [BE_W-1:0]    host_be,
  input  logic [BUS_W-1:0]   host_wdata,
  output logic               host_rvalid,
  output logic [BUS_W-1:0]   host_rdata,
  output logic               host_err,
  output logic               ram_we,
  output logic [IDX_W-1:0]   ram_widx,
  output logic [ENTRY_W-1:0] ram_wdata,
  output logic               ram_ren,
  output logic [IDX_W-1:0]   ram_ridx,
  input  logic [ENTRY_W-1:0] ram_rdata
);

  logic full_word;
  logic bad_wr;
  logic rvalid_d, rvalid_q;
  logic err_d, err_q;

  always_comb begin
    full_word = &host_be;
    bad_wr    = host_req & host_we & ~full_word;
    ram_we    = host_req & host_we & full_word;
    ram_widx  = host_addr[ADDR_W-1:2];
    ram_wdata = host_wdata[ENTRY_W-1:0];
    ram_ren   = host_req & ~host_we;
    ram_ridx  = host_addr[ADDR_W-1:2];
    rvalid_d  = ram_ren;
    err_d     = bad_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rvalid_q <= rvalid_d;
      err_q    <= err_d;
    end
  end

  always_comb begin
    host_rvalid = rvalid_q;
    host_err    = err_q;
    host_rdata  = '0;
    if (rvalid_q) host_rdata[ENTRY_W-1:0] = ram_rdata;
  end

endmodule

// File: rtl/pal_fmt.sv
module pal_fmt
  import lcd_pal_pkg::*;
(
  input  disp_mode_e             mode,
  input  logic                   valid,
  input  pal_entry_t             entry,
  output logic [PIX_OUT_W-1:0]   data
);

  localparam int RED_DROP = RED_W - STN_W;
  localparam int GRN_DROP = GRN_W - STN_W;
  localparam int BLU_DROP = BLU_W - STN_W;

  logic [STN_W-1:0] red_n, grn_n, blu_n;

  always_comb begin
    red_n = entry.red[RED_W-1:RED_DROP];
    grn_n = entry.grn[GRN_W-1:GRN_DROP];
    blu_n = entry.blu[BLU_W-1:BLU_DROP];
    data  = '0;
    if (valid) begin
      unique case (mode)
        DISP_STN_GREY:  data[STN_W-1:0]   = red_n;
        DISP_STN_COLOR: data[3*STN_W-1:0] = {red_n, grn_n, blu_n};
        DISP_TFT:       data = {entry.blu, 3'b000, entry.grn, 2'b00, entry.red, 3'b000};
        default:        data = '0;
      endcase
    end
  end

endmodule

// File: rtl/lcd_palette_lut.sv
module lcd_palette_lut
  import lcd_pal_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int BUS_W  = 32,
  localparam int ADDR_W = IDX_W + 2,
  localparam int BE_W   = BUS_W / 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_req,
  input  logic                  host_we,
  input  logic [ADDR_W-1:0]     host_addr,
  input  logic [BE_W-1:0]       host_be,
  input  logic [BUS_W-1:0]      host_wdata,
  output logic                  host_rvalid,
  output logic [BUS_W-1:0]      host_rdata,
  output logic                  host_err,
  input  logic                  pix_valid,
  input  logic [IDX_W-1:0]      pix_idx,
  input  logic [1:0]            pix_bpp,
  input  logic [1:0]            disp_mode,
  output logic                  out_valid,
  output logic [PIX_OUT_W-1:0]  out_data
);

  logic               ram_we, ram_ren;
  logic [IDX_W-1:0]   ram_widx, ram_ridx;
  logic [ENTRY_W-1:0] ram_wdata, host_entry, pix_entry;
  logic [IDX_W-1:0]   pix_idx_ext;

  logic       vld_d, vld_q;
  disp_mode_e mode_d, mode_q;

  pal_host_port #(.IDX_W(IDX_W), .ENTRY_W(ENTRY_W), .BUS_W(BUS_W)) u_host (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_req   (host_req),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_be    (host_be),
    .host_wdata (host_wdata),
    .host_rvalid(host_rvalid),
    .host_rdata (host_rdata),
    .host_err   (host_err),
    .ram_we     (ram_we),
    .ram_widx   (ram_widx),
    .ram_wdata  (ram_wdata),
    .ram_ren    (ram_ren),
    .ram_ridx   (ram_ridx),
    .ram_rdata  (host_entry)
  );

  pal_index_ext #(.IDX_W(IDX_W)) u_ext (
    .bpp_code(pix_bpp),
    .idx_in  (pix_idx),
    .idx_out (pix_idx_ext)
  );

  pal_ram #(.IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_ram (
    .clk    (clk),
    .wr_en  (ram_we),
    .wr_idx (ram_widx),
    .wr_data(ram_wdata),
    .pa_en  (pix_valid),
    .pa_idx (pix_idx_ext),
    .pa_data(pix_entry),
    .pb_en  (ram_ren),
    .pb_idx (ram_ridx),
    .pb_data(host_entry)
  );

  // Pixel side control pipe: next-state then register.
  always_comb begin
    vld_d  = pix_valid;
    mode_d = mode_q;
    if (pix_valid) mode_d = disp_mode_e'(disp_mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      mode_q <= DISP_STN_GREY;
    end else begin
      vld_q  <= vld_d;
      mode_q <= mode_d;
    end
  end

  pal_fmt u_fmt (
    .mode (mode_q),
    .valid(vld_q),
    .entry(pal_entry_t'(pix_entry)),
    .data (out_data)
  );

  assign out_valid = vld_q;

endmodule

// File: rtl/lcd_palette_lut_chk.sv
module lcd_palette_lut_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_req,
  input logic        host_we,
  input logic [3:0]  host_be,
  input logic        host_rvalid,
  input logic [31:0] host_rdata,
  input logic        host_err,
  input logic        pix_valid,
  input logic [1:0]  disp_mode,
  input logic        out_valid,
  input logic [23:0] out_data
);

  // R3
  bad_wr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_we && host_be != 4'hF) |=> host_err);

  // R3
  err_only_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_req && host_we && host_be != 4'hF) |=> !host_err);

  // R2
  rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we) |=> host_rvalid);

  // R2
  rd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> host_rdata[31:16] == 16'h0);

  // R4
  pix_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);

  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_data == 24'h0);

  // R6
  grey_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && disp_mode == 2'd0) |=> out_data[23:4] == 20'h0);

  // R8
  tft_gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && disp_mode == 2'd2) |=>
      (out_data[18:16] == 3'b0 && out_data[9:8] == 2'b0 && out_data[2:0] == 3'b0));

  // R9
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && disp_mode == 2'd3) |=> out_data == 24'h0);

endmodule

bind lcd_palette_lut lcd_palette_lut_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_req   (host_req),
  .host_we    (host_we),
  .host_be    (host_be),
  .host_rvalid(host_rvalid),
  .host_rdata (host_rdata),
  .host_err   (host_err),
  .pix_valid  (pix_valid),
  .disp_mode  (disp_mode),
  .out_valid  (out_valid),
  .out_data   (out_data)
);

// File: tb/test_lcd_palette_lut.sv
module test_lcd_palette_lut;

  logic        clk;
  logic        rst_n;
  logic        host_req, host_we;
  logic [9:0]  host_addr;
  logic [3:0]  host_be;
  logic [31:0] host_wdata;
  logic        host_rvalid;
  logic [31:0] host_rdata;
  logic        host_err;
  logic        pix_valid;
  logic [7:0]  pix_idx;
  logic [1:0]  pix_bpp, disp_mode;
  logic        out_valid;
  logic [23:0] out_data;

  int n_checks = 0;
  int n_fail   = 0;
  logic [15:0] model [256];
  logic [23:0] exp_q [$];
  string       tag_q [$];

  lcd_palette_lut i_lcd_palette_lut (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_be(host_be), .host_wdata(host_wdata),
    .host_rvalid(host_rvalid), .host_rdata(host_rdata), .host_err(host_err),
    .pix_valid(pix_valid), .pix_idx(pix_idx), .pix_bpp(pix_bpp),
    .disp_mode(disp_mode), .out_valid(out_valid), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] fmt(input logic [1:0] mode, input logic [15:0] e);
    logic [4:0] r; logic [5:0] g; logic [4:0] b;
    r = e[15:11]; g = e[10:5]; b = e[4:0];
    case (mode)
      2'd0:    return {20'h0, r[4:1]};
      2'd1:    return {12'h0, r[4:1], g[5:2], b[4:1]};
      2'd2:    return {b, 3'b0, g, 2'b0, r, 3'b0};
      default: return 24'h0;
    endcase
  endfunction

  function automatic logic [7:0] ext(input logic [1:0] bpp, input logic [7:0] idx);
    case (bpp)
      2'd0:    return idx & 8'h01;
      2'd1:    return idx & 8'h03;
      2'd2:    return idx & 8'h0F;
      default: return idx;
    endcase
  endfunction

  // Driver: one lookup per call, expected item pushed to the scoreboard.
  task automatic pix(input logic [7:0] idx, input logic [1:0] bpp,
                     input logic [1:0] mode, input string req);
    @(negedge clk);
    pix_valid = 1'b1; pix_idx = idx; pix_bpp = bpp; disp_mode = mode;
    exp_q.push_back(fmt(mode, model[ext(bpp, idx)]));
    tag_q.push_back(req);
  endtask

  task automatic pix_idle();
    @(negedge clk);
    pix_valid = 1'b0; pix_idx = 8'hFF; pix_bpp = 2'd3; disp_mode = 2'd3;
  endtask

  task automatic host_write(input logic [7:0] idx, input logic [31:0] d,
                            input logic [3:0] be, input logic [1:0] lo);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = {idx, lo};
    host_be = be; host_wdata = d;
    if (be == 4'hF) model[idx] = d[15:0];
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_read_chk(input logic [7:0] idx, input string req);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = {idx, 2'b00}; host_be = 4'h0;
    @(posedge clk); #2;
    check({req, " rvalid"}, {31'h0, host_rvalid}, 32'h1);
    check({req, " rdata"}, host_rdata, {16'h0, model[idx]});
    @(negedge clk);
    host_req = 1'b0;
    @(posedge clk); #2;
    check({req, " rdata idle"}, host_rdata, 32'h0);
  endtask

  // Monitor: compares each valid output against the scoreboard head.
  initial begin
    forever begin
      @(posedge clk); #2;
      if (rst_n) begin
        if (out_valid) begin
          if (exp_q.size() == 0) begin
            check("R4 unexpected out_valid", 32'h1, 32'h0);
          end else begin
            automatic logic [23:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(t, {8'h0, out_data}, {8'h0, e});
          end
        end else if (out_data !== 24'h0) begin
          check("R4 idle data", {8'h0, out_data}, 32'h0);
        end
      end
    end
  end

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    host_req = 0; host_we = 0; host_addr = 0; host_be = 0; host_wdata = 0;
    pix_valid = 0; pix_idx = 0; pix_bpp = 0; disp_mode = 0;
    repeat (3) @(posedge clk);
    #2;
    check("reset out_valid", {31'h0, out_valid}, 32'h0);
    check("reset host_err", {31'h0, host_err}, 32'h0);
    check("reset host_rvalid", {31'h0, host_rvalid}, 32'h0);
    check("reset out_data", {8'h0, out_data}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R1: fill table with junk in bits 31:16 and nonzero low address bits
    for (int i = 0; i < 256; i++) begin
      automatic logic [15:0] v = 16'(i * 16'h9E37) ^ 16'h5A5A;
      host_write(8'(i), {16'hDEAD ^ 16'(i), v}, 4'hF, 2'(i));
    end
    host_write(8'h00, 32'hABCD_FFFF, 4'hF, 2'b00);
    host_write(8'h01, 32'h1234_0000, 4'hF, 2'b11);

    // R1 / R2: readbacks
    host_read_chk(8'h00, "R1 R2 entry 00");
    host_read_chk(8'h01, "R1 R2 entry 01");
    host_read_chk(8'h7E, "R1 R2 entry 7E");
    host_read_chk(8'hFF, "R1 R2 entry FF");

    // R3: partial strobes refused and flagged
    foreach (host_be[k]) begin
      @(negedge clk);
      host_req = 1; host_we = 1; host_addr = {8'h10, 2'b00};
      host_be = 4'hF ^ (4'h1 << k); host_wdata = 32'h0000_1111;
      @(posedge clk); #2;
      check("R3 err pulse", {31'h0, host_err}, 32'h1);
      @(negedge clk); host_req = 0; host_we = 0;
      @(posedge clk); #2;
      check("R3 err single cycle", {31'h0, host_err}, 32'h0);
      host_read_chk(8'h10, "R3 entry unchanged");
    end
    @(negedge clk); host_req = 1; host_we = 1; host_be = 4'hF; host_addr = {8'h20, 2'b00};
    host_wdata = 32'h0000_4321; model[8'h20] = 16'h4321;
    @(posedge clk); #2;
    check("R3 no err on full write", {31'h0, host_err}, 32'h0);
    @(negedge clk); host_req = 0; host_we = 0;

    // R5..R9 with R11: all modes and widths, junk upper index bits, back-to-back
    for (int m = 0; m < 4; m++) begin
      for (int b = 0; b < 4; b++) begin
        pix(8'hFE, 2'(b), 2'(m), "R5 R11 width/mode sweep a");
        pix(8'hA5, 2'(b), 2'(m), "R5 R11 width/mode sweep b");
        pix(8'h5B, 2'(b), 2'(m), "R5 R11 width/mode sweep c");
      end
    end
    pix_idle();
    // R6, R7, R8, R9: entries with saturated and single fields
    host_write(8'h30, 32'h0000_FFFF, 4'hF, 2'b00);
    host_write(8'h31, 32'h0000_F800, 4'hF, 2'b00);
    host_write(8'h32, 32'h0000_07E0, 4'hF, 2'b00);
    host_write(8'h33, 32'h0000_001F, 4'hF, 2'b00);
    host_write(8'h34, 32'h0000_0821, 4'hF, 2'b00);
    for (int e = 8'h30; e <= 8'h34; e++) begin
      pix(8'(e), 2'd3, 2'd0, "R6 grey STN");
      pix(8'(e), 2'd3, 2'd1, "R7 colour STN");
      pix(8'(e), 2'd3, 2'd2, "R8 TFT");
      pix(8'(e), 2'd3, 2'd3, "R9 reserved");
    end
    pix_idle();
    repeat (2) @(negedge clk);

    // R10: collision returns old value, next lookup returns new
    @(negedge clk);
    pix_valid = 1; pix_idx = 8'h40; pix_bpp = 2'd3; disp_mode = 2'd2;
    exp_q.push_back(fmt(2'd2, model[8'h40])); tag_q.push_back("R10 old value on collision");
    host_req = 1; host_we = 1; host_be = 4'hF; host_addr = {8'h40, 2'b00};
    host_wdata = 32'h0000_C3A5; model[8'h40] = 16'hC3A5;
    @(negedge clk);
    host_req = 0; host_we = 0;
    exp_q.push_back(fmt(2'd2, model[8'h40])); tag_q.push_back("R10 new value after");
    pix_idle();

    // R4: idle gap keeps outputs low
    repeat (3) @(negedge clk);
    wait (exp_q.size() == 0);
    @(posedge clk); #2;
    check("R4 idle out_valid", {31'h0, out_valid}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule